// File: doc/BRIEF.md
# Multi-Rate Search and Lock Controller

This block is the digital control core of a multi-rate serial reclocker. It runs entirely on the fixed reference clock. It counts pulses from the divided VCO over a window of reference cycles and compares the count against an expected value. From that comparison it decides whether the loop has frequency lock. It also picks which candidate data rate the analog divider should be set to.

In automatic mode the block steps through the candidate rates until one of them locks. In manual mode it holds the rate chosen on the standard-select pins. The block reports the following:

- a lock flag;
- an SD/HD indication;
- the rate code, together with an output enable for the bidirectional select pins;
- a data-path select that chooses between the reclocked stream, the raw bypass path and a muted output.

Lock uses hysteresis. The loop enters lock when the count is within 1% of the expected value. Once locked, it stays locked until the error exceeds 2% or the phase loop drops out.

Top module: `rate_lock_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rate_idx_o` is 000, `lock_o` is 0, `sd_o` is 0 and `ss_code_o` is 000.
- R2: In auto mode, when a rate fails to lock for `DWELL_WINS` consecutive measured windows, the rate index advances in the order 000, 001, 010, 011, 100, 101 and then wraps to 000. Each step is taken at the end of a window.
- R3: In auto mode with `asi_i` high, the step after 000 goes to 010, so code 001 is skipped. A window measured at code 001 under those conditions never produces lock.
- R4: When unlocked, a window whose pulse count differs from `EXP_COUNT` by at most `EXP_COUNT/100` sets `lock_o`. The current rate index is then held.
- R5: When locked, `lock_o` clears at the end of a window if the count error exceeds `EXP_COUNT/50` or if `phase_act_i` is low. Otherwise `lock_o` stays high, including for errors between the two bands.
- R6: In manual mode (`auto_i` low), `rate_idx_o` follows `ss_code_i` and no search step happens. Codes 110 and 111 are ignored and leave the index unchanged. When `HD_EN` is 0, code 101 is also ignored.
- R7: `ss_oe_o` equals the registered `auto_i`. `ss_code_o` shows the rate index at the most recent lock entry, and 000 if no lock has occurred since reset.
- R8: `sd_o` is high only while locked to a rate other than 101. It is low when unlocked or when locked to 101.
- R9: `path_sel_o` is 01 (bypass) whenever `bypass_i` is high. It is also 01 when `autobyp_i` is high and the block is unlocked.
- R10: When not in bypass, `path_sel_o` is 10 (muted) while `mute_n_i` is low and 00 (reclocked) while it is high. `mute_n_i` has no effect in bypass.
- R11: In manual mode, a change of the effective rate index clears lock at once. The result of the measurement window then in progress is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| vco_pulse_i | input | 1 | Divided-VCO pulse, one count per high cycle |
| phase_act_i | input | 1 | Phase acquisition loop active |
| auto_i | input | 1 | 1 = automatic rate search, 0 = manual rate |
| ss_code_i | input | 3 | Manual rate code |
| asi_i | input | 1 | Remove rate 001 from the automatic search |
| bypass_i | input | 1 | Force bypass path |
| autobyp_i | input | 1 | Bypass while unlocked |
| mute_n_i | input | 1 | Active-low output mute |
| rate_idx_o | output | 3 | Rate index driven to the analog divider |
| ss_oe_o | output | 1 | Output enable for the rate-code pins |
| ss_code_o | output | 3 | Rate code shown when driving the pins |
| lock_o | output | 1 | Frequency lock indication |
| sd_o | output | 1 | High when locked to an SD rate |
| path_sel_o | output | 2 | 00 reclocked, 01 bypass, 10 muted |

## Verification
The bench targets the following corner cases:

- **Search wrap and ASI skip.** A design that mishandled either would show 001 while ASI is set, or would stop at 100 instead of reaching 101.
- **Hysteresis band between 1% and 2%.** Getting this wrong would either drop lock early or lock on a 1.5% error.
- **Manual code changes mid-window and invalid codes.** A faulty design would lock on a stale count or jump to 110/111.
- **Dropout of the phase loop while locked.**
- **Precedence of bypass over mute.** A faulty design would mute the bypassed stream.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

  typedef enum logic [1:0] {
    PATH_RECLK  = 2'd0,
    PATH_BYPASS = 2'd1,
    PATH_MUTE   = 2'd2
  } path_e;

  localparam logic [2:0] RATE_SLOWEST = 3'd0;
  localparam logic [2:0] RATE_177     = 3'd1;
  localparam logic [2:0] RATE_SD_TOP  = 3'd4;
  localparam logic [2:0] RATE_HD      = 3'd5;

  // Next candidate in the automatic sweep; the 177 slot is skipped on request
  function automatic logic [2:0] next_rate(input logic [2:0] cur,
                                           input logic       skip177,
                                           input logic       hd_en);
    logic [2:0] top;
    logic [2:0] n;
    top = hd_en ? RATE_HD : RATE_SD_TOP;
    n   = (cur >= top) ? RATE_SLOWEST : cur + 3'd1;
    if (skip177 && n == RATE_177) n = n + 3'd1;
    return n;
  endfunction

  function automatic logic code_ok(input logic [2:0] code, input logic hd_en);
    return (code <= RATE_SD_TOP) || (code == RATE_HD && hd_en);
  endfunction

endpackage

// File: rtl/rlc_freq_meter.sv
module rlc_freq_meter #(
  parameter int WIN_CYCLES = 1024,
  parameter int CW         = $clog2(WIN_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pulse_i,
  output logic          done_o,
  output logic [CW-1:0] count_o
);
  localparam int WW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYCLES - 1);

  logic [WW-1:0] win_q;
  logic [CW-1:0] acc_q;
  logic [CW-1:0] acc_nxt;

  assign acc_nxt = acc_q + {{(CW-1){1'b0}}, pulse_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q   <= '0;
      acc_q   <= '0;
      done_o  <= 1'b0;
      count_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (win_q == WIN_LAST) begin
        win_q   <= '0;
        acc_q   <= '0;
        count_o <= acc_nxt;
        done_o  <= 1'b1;
      end else begin
        win_q <= win_q + 1'b1;
        acc_q <= acc_nxt;
      end
    end
  end

  // R4: a window never reports more pulses than it has cycles
  assert_count_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (count_o <= CW'(WIN_CYCLES)));

endmodule

// File: rtl/rlc_search_fsm.sv
module rlc_search_fsm
  import rlc_pkg::*;
#(
  parameter int EXP_COUNT  = 1000,
  parameter int DWELL_WINS = 2,
  parameter bit HD_EN      = 1'b1,
  parameter int CW         = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done_i,
  input  logic [CW-1:0] count_i,
  input  logic          phase_i,
  input  logic          auto_i,
  input  logic [2:0]    code_i,
  input  logic          asi_i,
  output logic [2:0]    rate_o,
  output logic          lock_o,
  output logic [2:0]    last_o
);
  localparam int DW = (DWELL_WINS > 1) ? $clog2(DWELL_WINS) : 1;
  localparam logic [DW-1:0] DWELL_LAST = DW'(DWELL_WINS - 1);
  localparam logic [CW-1:0] EXP_V      = CW'(EXP_COUNT);
  localparam logic [CW-1:0] ENTER_TOL  = CW'(EXP_COUNT / 100);
  localparam logic [CW-1:0] LEAVE_TOL  = CW'(EXP_COUNT / 50);

  logic [2:0]    rate_q, man_idx, last_q;
  logic          lock_q, disc_q, chg, blocked;
  logic [DW-1:0] dwell_q;
  logic [CW-1:0] err;

  always_comb begin
    err     = (count_i >= EXP_V) ? count_i - EXP_V : EXP_V - count_i;
    man_idx = (!auto_i && code_ok(code_i, HD_EN)) ? code_i : rate_q;
    chg     = (man_idx != rate_q);
    blocked = auto_i && asi_i && (rate_q == RATE_177);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q  <= RATE_SLOWEST;
      lock_q  <= 1'b0;
      dwell_q <= '0;
      disc_q  <= 1'b0;
      last_q  <= RATE_SLOWEST;
    end else if (chg) begin
      rate_q  <= man_idx;
      lock_q  <= 1'b0;
      dwell_q <= '0;
      disc_q  <= 1'b1;
    end else if (done_i) begin
      if (disc_q) begin
        disc_q <= 1'b0;
      end else if (lock_q) begin
        if (!phase_i || err > LEAVE_TOL) begin
          lock_q  <= 1'b0;
          dwell_q <= '0;
        end
      end else if (err <= ENTER_TOL && !blocked) begin
        lock_q  <= 1'b1;
        last_q  <= rate_q;
        dwell_q <= '0;
      end else if (dwell_q == DWELL_LAST) begin
        dwell_q <= '0;
        if (auto_i) rate_q <= next_rate(rate_q, asi_i, HD_EN);
      end else begin
        dwell_q <= dwell_q + 1'b1;
      end
    end
  end

  assign rate_o = rate_q;
  assign lock_o = lock_q;
  assign last_o = last_q;

  // R2: a rate step not caused by a manual change follows the sweep order
  assert_sweep_order_R2: assert property (@(posedge clk) disable iff (rst)
    (rate_q != $past(rate_q) && !$past(chg))
      |-> rate_q == next_rate($past(rate_q), $past(asi_i), HD_EN));

  // R3: with ASI set in auto mode, lock is never taken on the 177 slot
  assert_asi_no177_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(lock_q) && $past(auto_i) && $past(asi_i)) |-> rate_q != RATE_177);

  // R4: lock is entered only from a measured window inside the narrow band
  assert_enter_band_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> ($past(done_i) && $past(err) <= ENTER_TOL));

  // R5: lock is left only for a wide error, phase dropout or a rate change
  assert_leave_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_q) |-> ($past(chg) || !$past(phase_i) || $past(err) > LEAVE_TOL));

endmodule

// File: rtl/rlc_out_stage.sv
module rlc_out_stage
  import rlc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lock_i,
  input  logic [2:0] last_i,
  input  logic       auto_i,
  input  logic       bypass_i,
  input  logic       autobyp_i,
  input  logic       mute_n_i,
  output logic       ss_oe_o,
  output logic [2:0] ss_code_o,
  output logic       lock_o,
  output logic       sd_o,
  output path_e      path_o,
  input  logic [2:0] rate_i
);
  path_e path_nxt;

  always_comb begin
    if (bypass_i || (autobyp_i && !lock_i)) path_nxt = PATH_BYPASS;
    else if (!mute_n_i)                      path_nxt = PATH_MUTE;
    else                                     path_nxt = PATH_RECLK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_oe_o   <= 1'b0;
      ss_code_o <= RATE_SLOWEST;
      lock_o    <= 1'b0;
      sd_o      <= 1'b0;
      path_o    <= PATH_RECLK;
    end else begin
      ss_oe_o   <= auto_i;
      ss_code_o <= last_i;
      lock_o    <= lock_i;
      sd_o      <= lock_i && (rate_i != RATE_HD);
      path_o    <= path_nxt;
    end
  end

  // R8: the SD indication implies lock
  assert_sd_needs_lock_R8: assert property (@(posedge clk) disable iff (rst)
    sd_o |-> lock_o);

  // R9: a forced bypass always wins
  assert_bypass_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bypass_i)) |-> path_o == PATH_BYPASS);

  // R10: the muted path is never chosen while bypass is forced
  assert_mute_not_in_bypass_R10: assert property (@(posedge clk) disable iff (rst)
    (path_o == PATH_MUTE) |-> !$past(bypass_i));

endmodule

// File: rtl/rate_lock_ctrl.sv
module rate_lock_ctrl
  import rlc_pkg::*;
#(
  parameter int WIN_CYCLES = 1024,
  parameter int EXP_COUNT  = 1000,
  parameter int DWELL_WINS = 2,
  parameter bit HD_EN      = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vco_pulse_i,
  input  logic       phase_act_i,
  input  logic       auto_i,
  input  logic [2:0] ss_code_i,
  input  logic       asi_i,
  input  logic       bypass_i,
  input  logic       autobyp_i,
  input  logic       mute_n_i,
  output logic [2:0] rate_idx_o,
  output logic       ss_oe_o,
  output logic [2:0] ss_code_o,
  output logic       lock_o,
  output logic       sd_o,
  output logic [1:0] path_sel_o
);
  localparam int CW = $clog2(WIN_CYCLES + 1);

  logic          done;
  logic [CW-1:0] count;
  logic [2:0]    rate, last;
  logic          lock;
  path_e         path;

  rlc_freq_meter #(.WIN_CYCLES(WIN_CYCLES), .CW(CW)) u_meter (
    .clk(clk), .rst(rst), .pulse_i(vco_pulse_i),
    .done_o(done), .count_o(count)
  );

  rlc_search_fsm #(.EXP_COUNT(EXP_COUNT), .DWELL_WINS(DWELL_WINS),
                   .HD_EN(HD_EN), .CW(CW)) u_fsm (
    .clk(clk), .rst(rst), .done_i(done), .count_i(count),
    .phase_i(phase_act_i), .auto_i(auto_i), .code_i(ss_code_i),
    .asi_i(asi_i), .rate_o(rate), .lock_o(lock), .last_o(last)
  );

  rlc_out_stage u_out (
    .clk(clk), .rst(rst), .lock_i(lock), .last_i(last), .auto_i(auto_i),
    .bypass_i(bypass_i), .autobyp_i(autobyp_i), .mute_n_i(mute_n_i),
    .ss_oe_o(ss_oe_o), .ss_code_o(ss_code_o), .lock_o(lock_o),
    .sd_o(sd_o), .path_o(path), .rate_i(rate)
  );

  assign rate_idx_o = rate;
  assign path_sel_o = path;

endmodule

// File: tb/rate_lock_ctrl_tb.sv
module rate_lock_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN   = 1024;
  localparam int EXP   = 1000;
  localparam int DWELL = 2;
  localparam int NWIN  = 140;
  localparam int ENT   = EXP / 100;
  localparam int LEV   = EXP / 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vco_pulse_i = 1'b0, phase_act_i = 1'b1, auto_i = 1'b1;
  logic [2:0] ss_code_i = 3'd0;
  logic asi_i = 1'b0, bypass_i = 1'b0, autobyp_i = 1'b0, mute_n_i = 1'b1;
  logic [2:0] rate_idx_o, ss_code_o;
  logic ss_oe_o, lock_o, sd_o;
  logic [1:0] path_sel_o;

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit done_flag = 0;

  // bench model of the controller state
  int m_idx = 0, m_last = 0, m_dwell = 0;
  bit m_lock = 0, m_disc = 0;
  int true_rate = -1, offset = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rate_lock_ctrl dut_i (
    .clk(clk), .rst(rst), .vco_pulse_i(vco_pulse_i), .phase_act_i(phase_act_i),
    .auto_i(auto_i), .ss_code_i(ss_code_i), .asi_i(asi_i), .bypass_i(bypass_i),
    .autobyp_i(autobyp_i), .mute_n_i(mute_n_i), .rate_idx_o(rate_idx_o),
    .ss_oe_o(ss_oe_o), .ss_code_o(ss_code_o), .lock_o(lock_o), .sd_o(sd_o),
    .path_sel_o(path_sel_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int sweep_next(input int cur, input bit skip);
    int n;
    n = (cur == 5) ? 0 : cur + 1;
    if (skip && n == 1) n = 2;
    return n;
  endfunction

  function automatic bit valid_code(input int c);
    return c <= 5;
  endfunction

  function automatic int exp_path();
    if (bypass_i || (autobyp_i && !m_lock)) return 1;
    if (!mute_n_i) return 2;
    return 0;
  endfunction

  function automatic int window_count();
    if (m_idx == true_rate) return EXP + offset;
    return EXP - 100 - m_idx * 10;
  endfunction

  // control changes placed mid-window
  task automatic set_controls(input int w);
    if (w < 13) begin
      auto_i = 1; asi_i = 0; true_rate = -1;
    end else if (w < 23) begin
      asi_i = 1;
    end else if (w < 35) begin
      asi_i = 0; true_rate = 3;
      autobyp_i = (w < 29);
      mute_n_i  = !(w >= 27 && w <= 30);
      bypass_i  = (w == 29);
      if (w < 30)       offset = 8;
      else if (w < 33)  offset = 15;  // between bands: lock held (R5)
      else if (w == 33) offset = -21; // beyond 2%: lock lost (R5)
      else              offset = -10;
    end else if (w < 38) begin
      offset = 0; phase_act_i = (w == 37); // phase dropout (R5)
    end else if (w < 48) begin
      phase_act_i = 1; auto_i = 0; true_rate = 2; offset = 3;
      case (w)
        38, 39, 40: ss_code_i = 3'd2;
        41, 42:     ss_code_i = 3'd7; // ignored (R6)
        43, 44:     begin ss_code_i = 3'd5; true_rate = 5; end
        45:         ss_code_i = 3'd6; // ignored (R6)
        default:    begin ss_code_i = 3'd1; asi_i = 1; true_rate = 1; end
      endcase
    end else begin
      auto_i      = ($urandom_range(3) != 0);
      ss_code_i   = 3'($urandom_range(7));
      asi_i       = ($urandom_range(2) == 0);
      bypass_i    = ($urandom_range(5) == 0);
      autobyp_i   = ($urandom_range(1) == 0);
      mute_n_i    = ($urandom_range(3) != 0);
      phase_act_i = ($urandom_range(7) != 0);
      if ($urandom_range(4) == 0) true_rate = int'($urandom_range(6)) - 1;
      offset      = int'($urandom_range(60)) - 30;
    end
  endtask

  task automatic model_mid();
    int ni;
    ni = (!auto_i && valid_code(int'(ss_code_i))) ? int'(ss_code_i) : m_idx;
    if (ni != m_idx) begin // R11
      m_idx = ni; m_lock = 0; m_dwell = 0; m_disc = 1;
    end
  endtask

  task automatic model_end(input int k);
    int e;
    e = (k > EXP) ? k - EXP : EXP - k;
    if (m_disc) m_disc = 0;
    else if (m_lock) begin
      if (!phase_act_i || e > LEV) begin m_lock = 0; m_dwell = 0; end
    end else if (e <= ENT && !(auto_i && asi_i && m_idx == 1)) begin
      m_lock = 1; m_last = m_idx; m_dwell = 0;
    end else if (m_dwell == DWELL - 1) begin
      m_dwell = 0;
      if (auto_i) m_idx = sweep_next(m_idx, asi_i);
    end else m_dwell++;
  endtask

  task automatic check_all();
    chk("R2/R3/R6 rate index", int'(rate_idx_o), m_idx);
    chk("R4/R5/R11 lock", int'(lock_o), int'(m_lock));
    chk("R8 sd indication", int'(sd_o), int'(m_lock && m_idx != 5));
    chk("R7 pin enable", int'(ss_oe_o), int'(auto_i));
    chk("R7 shown code", int'(ss_code_o), m_last);
    chk("R9/R10 path select", int'(path_sel_o), exp_path());
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000 && !done_flag) begin
      done_flag = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int k;
    void'($urandom(32'd20241));
    repeat (4) @(negedge clk);
    chk("R1 reset rate", int'(rate_idx_o), 0);
    chk("R1 reset lock", int'(lock_o), 0);
    chk("R1 reset sd", int'(sd_o), 0);
    chk("R1 reset code", int'(ss_code_o), 0);
    for (int w = 0; w < NWIN; w++) begin
      k = window_count();
      for (int c = 0; c < WIN; c++) begin
        @(negedge clk);
        if (w == 0 && c == 0) rst = 0;
        if (w == 0 && c == 2) begin
          chk("R1 rate after reset", int'(rate_idx_o), 0);
          chk("R1 lock after reset", int'(lock_o), 0);
        end
        vco_pulse_i = (((c + 1) * k) / WIN) != ((c * k) / WIN);
        if (c == WIN / 2) begin
          set_controls(w);
          model_mid();
        end
        if (c == (3 * WIN) / 4) check_all();
      end
      model_end(k);
    end
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule